// File: doc/BRIEF.md
# Free-Running 16-bit Timer with Capture and Compare

This block keeps a 16-bit up-counter that steps once every four clocks while its count enable is high. An edge on an external pin copies the counter into a capture register. When the counter steps onto a programmed compare value, a chosen level is driven onto a compare output pin. Three sticky flags (capture, compare, overflow) report these events, and each one can raise a shared interrupt line through its own enable.

Software reaches the block over an 8-bit register bus with separate read and write strobes. Each access takes one cycle. Read data is combinational from the address, and read side effects take hold at the clock edge that ends the access. Byte ordering rules keep 16-bit values coherent:
- Reading a high byte holds the matching low byte for the next low-byte read.
- Writing the compare high byte holds off matching until the low byte follows.

A flag is cleared by a two-step sequence: a status read that sees the flag set, then a read or write of the low byte that belongs to that flag. A second, alternate view of the counter never takes part in the overflow clear.

The register offsets are:

| Offset | Register |
|--------|----------|
| 0 | control |
| 1 | status |
| 2 | counter high |
| 3 | counter low |
| 4 | alternate counter high |
| 5 | alternate counter low |
| 6 | capture high |
| 7 | capture low |
| 8 | compare high |
| 9 | compare low |

All other offsets read as zero. The control register has five bits:

| Bit | Meaning |
|-----|---------|
| 0 | edge select (1 = rising, 0 = falling) |
| 1 | compare output level |
| 2 | capture interrupt enable |
| 3 | compare interrupt enable |
| 4 | overflow interrupt enable |

The status register has three flag bits: bit 0 capture, bit 1 compare, bit 2 overflow.

Top module: `tmr16_capcmp`

## Requirements
- R1: After reset the counter reads $FFFC, the status register reads 0, control bits 4..1 read 0, and cmp_out_o and irq_o are low. Control bit 0 (edge select) keeps the value it had before reset.
- R2: While cnt_en_i is high, the counter advances by one every fourth clock. While it is low, the counter and its four-clock phase both hold.
- R3: Writes to offsets 1 through 5 change nothing visible.
- R4: Reading offset 2 (or 4) saves the counter low byte at that moment. The next read of offset 3 (or 5, each with its own store) returns the saved byte. A low-byte read that does not follow a high-byte read returns the live low byte.
- R5: A counter step from $FFFF to $0000 sets status bit 2. A read of offset 3 that follows a status read which saw bit 2 set clears it. Reads of offsets 4 and 5 never clear it.
- R6: A selected edge on cap_pin_i is seen at the third rising clock after the pin changes. At that edge the capture register loads the counter value from before that edge plus one. The other edge direction captures nothing.
- R7: A capture sets status bit 0. A read of offset 7 that follows a status read which saw bit 0 set clears it.
- R8: When, with matching not held off, the counter steps onto the compare value, status bit 1 sets and cmp_out_o takes control bit 1 at that same edge.
- R9: A write to offset 8 holds off compare matches until a write to offset 9.
- R10: A read or a write of offset 9 that follows a status read which saw bit 1 set clears status bit 1.
- R11: irq_o is high exactly when some status bit i is set together with control bit i+2.
- R12: A flag that is set and cleared in the same cycle ends up set, and it needs a new status read before it can be cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cnt_en_i | input | 1 | Count enable; low freezes the counter and its phase |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| cmp_out_o | output | 1 | Compare output level |
| irq_o | output | 1 | Interrupt request |

## Verification
The sharpest same-cycle collision is a flag being set by its event in the very cycle its clearing low-byte access lands. The bench provokes this directly by timing a capture-pin edge so that its synchronized detection coincides with the capture-low read that follows an arming status read. A long mixed phase then lets overflows and compare matches meet counter-low and compare-low accesses by chance. The bench judges the result with a per-cycle model in which a set beats a clear and the arm is consumed. A second collision, a compare-low write meeting a match in the same cycle, is judged against the pre-write compare value and hold-off state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_H = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_L = 4'd3;
  localparam logic [ADDR_W-1:0] A_ALT_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_ALT_L = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAP_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP_H = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMP_L = 4'd9;

  localparam int NUM_FLAGS = 3;
  localparam int F_CAP = 0;
  localparam int F_CMP = 1;
  localparam int F_OVF = 2;

  localparam int B_EDGE = 0;
  localparam int B_OLVL = 1;
  localparam int B_IE0  = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_l,
  input  logic cnt_en_i,
  output logic tick_o
);
  localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PS_W-1:0] phase_q, phase_d;

  always_comb begin
    tick_o  = cnt_en_i && (phase_q == PS_W'(DIV - 1));
    phase_d = phase_q;
    if (cnt_en_i) phase_d = tick_o ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  p_phase_frozen_r2: assert property (@(posedge clk) disable iff (!rst_l)
    !cnt_en_i |=> $stable(phase_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    next_o = cnt_q + 1'b1;
    wrap_o = tick_i && (cnt_q == '1);
    cnt_d  = tick_i ? next_o : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_l)
    tick_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_l)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         pin_i,
  input  logic         rise_sel_i,
  input  logic [W-1:0] cnt_i,
  output logic         cap_evt_o,
  output logic [W-1:0] cap_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic [W-1:0]           cap_q, cap_d;
  logic                   seen;

  always_comb begin
    for (int i = 0; i < SYNC_STAGES; i++)
      sync_d[i] = (i == 0) ? pin_i : sync_q[(i == 0) ? 0 : i - 1];
  end

  always_comb begin
    seen      = sync_q[SYNC_STAGES-1];
    cap_evt_o = rise_sel_i ? (seen && !prev_q) : (!seen && prev_q);
    cap_d     = cap_evt_o ? W'(cnt_i + 1'b1) : cap_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= seen;
      cap_q  <= cap_d;
    end
  end

  assign cap_o = cap_q;

  p_cap_value_r6: assert property (@(posedge clk) disable iff (!rst_l)
    cap_evt_o |=> cap_q == W'($past(cnt_i) + 1'b1));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int DW = 8,
  parameter int W  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          tick_i,
  input  logic [W-1:0]  next_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  cmp_o,
  output logic          match_o
);
  logic [W-1:0] cmp_q, cmp_d;
  logic         hold_q, hold_d;

  always_comb begin
    match_o = tick_i && !hold_q && (next_i == cmp_q);
    cmp_d   = cmp_q;
    hold_d  = hold_q;
    if (wr_hi_i) begin
      cmp_d[W-1:DW] = wdata_i;
      hold_d        = 1'b1;
    end
    if (wr_lo_i) begin
      cmp_d[DW-1:0] = wdata_i;
      hold_d        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cmp_q  <= '1;
      hold_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      hold_q <= hold_d;
    end
  end

  assign cmp_o = cmp_q;

  p_hold_persists_r9: assert property (@(posedge clk) disable iff (!rst_l)
    (hold_q && !wr_lo_i) |=> hold_q);
endmodule

// File: rtl/tmr16_capcmp.sv
module tmr16_capcmp
  import tmr_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          PRESCALE    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CNT_RESET   = 32'h0000_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en_i,
  input  logic              cap_pin_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              cmp_out_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_l = rst_pipe_q[1];

  logic             tick, wrap, cap_evt, match;
  logic [CNT_W-1:0] cnt, cnt_next, cap_val, cmp_val;

  tmr_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk(clk), .rst_l(rst_l), .cnt_en_i(cnt_en_i), .tick_o(tick));

  tmr_counter #(.W(CNT_W), .RST_VAL(CNT_W'(CNT_RESET))) u_counter (
    .clk(clk), .rst_l(rst_l), .tick_i(tick),
    .cnt_o(cnt), .next_o(cnt_next), .wrap_o(wrap));

  // control register, edge select kept across reset
  logic                 edge_q;
  logic                 olvl_q, olvl_d;
  logic [NUM_FLAGS-1:0] ie_q, ie_d;

  tmr_capture #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst_l(rst_l), .pin_i(cap_pin_i), .rise_sel_i(edge_q),
    .cnt_i(cnt), .cap_evt_o(cap_evt), .cap_o(cap_val));

  // bus decode
  logic rd_stat, rd_cnt_h, rd_cnt_l, rd_alt_h, rd_alt_l, rd_cap_l;
  logic wr_ctrl, wr_cmp_h, wr_cmp_l, acc_cmp_l;
  always_comb begin
    rd_stat   = bus_rd_i && (bus_addr_i == A_STAT);
    rd_cnt_h  = bus_rd_i && (bus_addr_i == A_CNT_H);
    rd_cnt_l  = bus_rd_i && (bus_addr_i == A_CNT_L);
    rd_alt_h  = bus_rd_i && (bus_addr_i == A_ALT_H);
    rd_alt_l  = bus_rd_i && (bus_addr_i == A_ALT_L);
    rd_cap_l  = bus_rd_i && (bus_addr_i == A_CAP_L);
    wr_ctrl   = bus_wr_i && (bus_addr_i == A_CTRL);
    wr_cmp_h  = bus_wr_i && (bus_addr_i == A_CMP_H);
    wr_cmp_l  = bus_wr_i && (bus_addr_i == A_CMP_L);
    acc_cmp_l = (bus_rd_i || bus_wr_i) && (bus_addr_i == A_CMP_L);
  end

  tmr_compare #(.DW(DATA_W), .W(CNT_W)) u_compare (
    .clk(clk), .rst_l(rst_l), .tick_i(tick), .next_i(cnt_next),
    .wr_hi_i(wr_cmp_h), .wr_lo_i(wr_cmp_l), .wdata_i(bus_wdata_i),
    .cmp_o(cmp_val), .match_o(match));

  // flags and their clear sequence
  logic [NUM_FLAGS-1:0] flag_q, flag_d, arm_q, arm_d, flag_set, flag_clr;
  always_comb begin
    flag_set        = '0;
    flag_set[F_CAP] = cap_evt;
    flag_set[F_CMP] = match;
    flag_set[F_OVF] = wrap;
    flag_clr        = '0;
    flag_clr[F_CAP] = arm_q[F_CAP] && rd_cap_l;
    flag_clr[F_CMP] = arm_q[F_CMP] && acc_cmp_l;
    flag_clr[F_OVF] = arm_q[F_OVF] && rd_cnt_l;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      flag_d[i] = flag_set[i] | (flag_q[i] & ~flag_clr[i]);
      arm_d[i]  = rd_stat ? flag_q[i] : (flag_clr[i] ? 1'b0 : arm_q[i]);
    end
  end

  // coherent low-byte stores
  logic [DATA_W-1:0] cnt_lat_q, cnt_lat_d, alt_lat_q, alt_lat_d;
  logic              cnt_lat_v_q, cnt_lat_v_d, alt_lat_v_q, alt_lat_v_d;
  logic              cmp_out_q, cmp_out_d;
  always_comb begin
    cnt_lat_d   = rd_cnt_h ? cnt[DATA_W-1:0] : cnt_lat_q;
    cnt_lat_v_d = rd_cnt_h ? 1'b1 : (rd_cnt_l ? 1'b0 : cnt_lat_v_q);
    alt_lat_d   = rd_alt_h ? cnt[DATA_W-1:0] : alt_lat_q;
    alt_lat_v_d = rd_alt_h ? 1'b1 : (rd_alt_l ? 1'b0 : alt_lat_v_q);
    olvl_d      = wr_ctrl ? bus_wdata_i[B_OLVL] : olvl_q;
    ie_d        = wr_ctrl ? bus_wdata_i[B_IE0 +: NUM_FLAGS] : ie_q;
    cmp_out_d   = match ? olvl_q : cmp_out_q;
  end

  always_ff @(posedge clk) begin
    if (wr_ctrl) edge_q <= bus_wdata_i[B_EDGE];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      flag_q      <= '0;
      arm_q       <= '0;
      olvl_q      <= 1'b0;
      ie_q        <= '0;
      cnt_lat_q   <= '0;
      cnt_lat_v_q <= 1'b0;
      alt_lat_q   <= '0;
      alt_lat_v_q <= 1'b0;
      cmp_out_q   <= 1'b0;
    end else begin
      flag_q      <= flag_d;
      arm_q       <= arm_d;
      olvl_q      <= olvl_d;
      ie_q        <= ie_d;
      cnt_lat_q   <= cnt_lat_d;
      cnt_lat_v_q <= cnt_lat_v_d;
      alt_lat_q   <= alt_lat_d;
      alt_lat_v_q <= alt_lat_v_d;
      cmp_out_q   <= cmp_out_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_EDGE]              = edge_q;
        bus_rdata_o[B_OLVL]              = olvl_q;
        bus_rdata_o[B_IE0 +: NUM_FLAGS]  = ie_q;
      end
      A_STAT:  bus_rdata_o[NUM_FLAGS-1:0] = flag_q;
      A_CNT_H: bus_rdata_o = cnt[CNT_W-1:DATA_W];
      A_CNT_L: bus_rdata_o = cnt_lat_v_q ? cnt_lat_q : cnt[DATA_W-1:0];
      A_ALT_H: bus_rdata_o = cnt[CNT_W-1:DATA_W];
      A_ALT_L: bus_rdata_o = alt_lat_v_q ? alt_lat_q : cnt[DATA_W-1:0];
      A_CAP_H: bus_rdata_o = cap_val[CNT_W-1:DATA_W];
      A_CAP_L: bus_rdata_o = cap_val[DATA_W-1:0];
      A_CMP_H: bus_rdata_o = cmp_val[CNT_W-1:DATA_W];
      A_CMP_L: bus_rdata_o = cmp_val[DATA_W-1:0];
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o     = |(flag_q & ie_q);
  assign cmp_out_o = cmp_out_q;

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (tick && (cnt == '1)) |=> flag_q[F_OVF]);
  p_cmp_out_r8: assert property (@(posedge clk) disable iff (!rst_l)
    match |=> cmp_out_q == $past(olvl_q));
  p_quiet_irq_r11: assert property (@(posedge clk) disable iff (!rst_l)
    (flag_q == '0) |-> !irq_o);

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag_chk
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_l)
      flag_set[gi] |=> flag_q[gi]);
  end
endmodule

// File: tb/tmr16_capcmp_bench.sv
module tmr16_capcmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;
  localparam int PS         = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0, cap_pin = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd1;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cmp_out, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_capcmp u_tmr16_capcmp (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .cap_pin_i(cap_pin),
    .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cmp_out_o(cmp_out), .irq_o(irq));

  // behavioural reference state
  int       m_cnt, m_ps, m_cap, m_cmp, m_clat, m_alat;
  bit       m_hold, m_edge, m_olvl, m_cout, m_clv, m_alv, m_s1, m_s2, m_p;
  bit [2:0] m_ie, m_flag, m_arm;

  int   n_vec = 0, n_miss = 0;
  bit   done = 1'b0;
  bit   g_en = 1'b0, g_pin = 1'b0;
  int   last_rd;
  bit   last_irq, last_cout;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int a);
    case (a)
      0:       return "R11";
      1:       return "R5";
      2, 3:    return "R2";
      4, 5:    return "R4";
      6, 7:    return "R6";
      8, 9:    return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic int m_rdata(int a);
    case (a)
      0: return int'(m_edge) | (int'(m_olvl) << 1) | (int'(m_ie) << 2);
      1: return int'(m_flag);
      2, 4: return (m_cnt >> 8) & 'hFF;
      3: return m_clv ? m_clat : (m_cnt & 'hFF);
      5: return m_alv ? m_alat : (m_cnt & 'hFF);
      6: return (m_cap >> 8) & 'hFF;
      7: return m_cap & 'hFF;
      8: return (m_cmp >> 8) & 'hFF;
      9: return m_cmp & 'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 'hFFFC; m_ps = 0; m_cap = 0; m_cmp = 'hFFFF; m_hold = 0;
    m_olvl = 0; m_ie = 0; m_flag = 0; m_arm = 0; m_cout = 0;
    m_clat = 0; m_alat = 0; m_clv = 0; m_alv = 0;
    m_s1 = 0; m_s2 = 0; m_p = 0;
  endtask

  task automatic model_step(bit rd, bit wr, int a, int wd, bit pin, bit en);
    bit tick, capev, match, wrap;
    bit [2:0] setv, clrv, nf, na;
    int nxt;
    tick  = en && (m_ps == PS - 1);
    nxt   = (m_cnt + 1) & 'hFFFF;
    wrap  = tick && (m_cnt == 'hFFFF);
    capev = m_edge ? (m_s2 && !m_p) : (!m_s2 && m_p);
    match = tick && !m_hold && (nxt == m_cmp);
    setv  = {wrap, match, capev};
    clrv  = {m_arm[2] && rd && a == 3,
             m_arm[1] && (rd || wr) && a == 9,
             m_arm[0] && rd && a == 7};
    for (int i = 0; i < 3; i++) begin
      nf[i] = setv[i] | (m_flag[i] & ~clrv[i]);
      na[i] = (rd && a == 1) ? m_flag[i] : (clrv[i] ? 1'b0 : m_arm[i]);
    end
    if (match) m_cout = m_olvl;
    if (capev) m_cap = nxt;
    if (rd && a == 2) begin m_clat = m_cnt & 'hFF; m_clv = 1; end
    else if (rd && a == 3) m_clv = 0;
    if (rd && a == 4) begin m_alat = m_cnt & 'hFF; m_alv = 1; end
    else if (rd && a == 5) m_alv = 0;
    if (wr && a == 0) begin
      m_edge = wd[0]; m_olvl = wd[1]; m_ie = 3'((wd >> 2) & 7);
    end
    if (wr && a == 8) begin m_cmp = (m_cmp & 'hFF) | ((wd & 'hFF) << 8); m_hold = 1; end
    if (wr && a == 9) begin m_cmp = (m_cmp & 'hFF00) | (wd & 'hFF); m_hold = 0; end
    m_flag = nf; m_arm = na;
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin;
    if (tick) m_cnt = nxt;
    if (en) m_ps = tick ? 0 : m_ps + 1;
  endtask

  // one bus cycle: drive at the falling edge, compare, advance the model
  task automatic cyc(bit rd, bit wr, int a, int wd);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = 4'(a); bus_wdata = 8'(wd);
    cap_pin = g_pin; cnt_en = g_en;
    #1;
    last_rd = int'(bus_rdata); last_irq = irq; last_cout = cmp_out;
    chk(tag_of(a), int'(bus_rdata), m_rdata(a));
    chk("R11", int'(irq), int'(|(m_flag & m_ie)));
    chk("R8", int'(cmp_out), int'(m_cout));
    model_step(rd, wr, a, wd, g_pin, g_en);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = 4'd1;
    g_pin = 0; g_en = 0; cap_pin = 0; cnt_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    model_reset();
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    m_edge = 0;
    do_reset();
    cyc(0, 1, 0, 'h1F);
    do_reset();
    // R1 reset state, edge select retained
    cyc(1, 0, 0, 0); chk("R1", last_rd, 'h01);
    cyc(1, 0, 2, 0); chk("R1", last_rd, 'hFF);
    cyc(1, 0, 3, 0); chk("R1", last_rd, 'hFC);
    cyc(1, 0, 1, 0); chk("R1", last_rd, 'h00);
    chk("R1", int'(last_irq), 0); chk("R1", int'(last_cout), 0);
    // R2 frozen then counting
    idle(20);
    cyc(1, 0, 2, 0); cyc(1, 0, 3, 0); chk("R2", last_rd, 'hFC);
    g_en = 1; idle(8); g_en = 0;
    cyc(1, 0, 2, 0); chk("R2", last_rd, 'hFF);
    cyc(1, 0, 3, 0); chk("R2", last_rd, 'hFE);
    // R3 writes to read-only offsets
    cyc(0, 1, 2, 'h12); cyc(0, 1, 3, 'h34); cyc(0, 1, 4, 'h56);
    cyc(0, 1, 5, 'h78); cyc(0, 1, 1, 'hFF);
    cyc(1, 0, 2, 0); chk("R3", last_rd, 'hFF);
    cyc(1, 0, 3, 0); chk("R3", last_rd, 'hFE);
    cyc(1, 0, 1, 0); chk("R3", last_rd, 'h00);
    // R5 overflow, alternate view does not clear
    g_en = 1; idle(8); g_en = 0;
    cyc(1, 0, 1, 0); chk("R5", last_rd, 'h06);
    cyc(1, 0, 4, 0); cyc(1, 0, 5, 0);
    cyc(1, 0, 1, 0); chk("R5", last_rd, 'h06);
    cyc(1, 0, 2, 0); cyc(1, 0, 3, 0);
    cyc(1, 0, 1, 0); chk("R5", last_rd, 'h02);
    // R10 compare-low write after arming status read
    cyc(0, 1, 9, 'h10);
    cyc(1, 0, 1, 0); chk("R10", last_rd, 'h00);
    // R9 hold-off after high-byte write
    cyc(0, 1, 0, 'h03);
    cyc(0, 1, 8, 'h00);
    g_en = 1; idle(100); g_en = 0;
    cyc(1, 0, 1, 0); chk("R9", last_rd, 'h00); chk("R9", int'(last_cout), 0);
    // R8 match drives the level
    cyc(0, 1, 9, 'h30);
    g_en = 1; idle(100); g_en = 0;
    cyc(1, 0, 1, 0); chk("R8", last_rd, 'h02); chk("R8", int'(last_cout), 1);
    // R6 rising capture, counter frozen at 0x0032
    g_pin = 1; idle(4);
    cyc(1, 0, 1, 0); chk("R6", last_rd, 'h03);
    cyc(1, 0, 6, 0); chk("R6", last_rd, 'h00);
    cyc(1, 0, 7, 0); chk("R6", last_rd, 'h33);
    cyc(1, 0, 1, 0); chk("R7", last_rd, 'h02);
    g_pin = 0; idle(4);
    cyc(1, 0, 1, 0); chk("R6", last_rd, 'h02);
    // R11 interrupt enables
    cyc(0, 1, 0, 'h0B); idle(1); chk("R11", int'(last_irq), 1);
    cyc(0, 1, 0, 'h07); idle(1); chk("R11", int'(last_irq), 0);
    // R12 capture lands on the clearing read
    g_pin = 1; idle(4); g_pin = 0; idle(4);
    cyc(1, 0, 1, 0); chk("R12", last_rd, 'h03);
    g_pin = 1; idle(2);
    cyc(1, 0, 7, 0);
    cyc(1, 0, 1, 0); chk("R12", last_rd, 'h03);
    // R4 coherent low byte while counting
    g_en = 1;
    cyc(1, 0, 2, 0); idle(8);
    cyc(1, 0, 3, 0); chk("R4", last_rd, 'h32);
    // mixed phase
    for (int i = 0; i < 6000; i++) begin
      int r, off;
      if (i % 50 == 0) g_en = ($urandom % 5) != 0;
      if ($urandom % 12 == 0) g_pin = ~g_pin;
      r   = $urandom % 100;
      off = (m_cnt + int'($urandom % 6)) & 'hFFFF;
      if (r < 30)      cyc(1, 0, int'($urandom % 12), 0);
      else if (r < 42) cyc(1, 0, 1, 0);
      else if (r < 47) cyc(0, 1, 0, int'($urandom % 256));
      else if (r < 55) cyc(0, 1, 8, off >> 8);
      else if (r < 63) cyc(0, 1, 9, off & 'hFF);
      else if (r < 68) cyc(0, 1, 1 + int'($urandom % 5), int'($urandom % 256));
      else             cyc(0, 0, 1, 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule